// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hazard Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline. It looks at the two source register numbers of the instruction being decoded. It compares them with the destination register of the two older instructions now in the execute and memory stages. For each operand it chooses where the value comes from: the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. The choice is a two-bit select that steers the operand latches.

The register file writes early in a cycle and reads late in the same cycle. So a value that is being written back is already visible to the read, and no third forwarding level exists. A load result cannot reach the instruction directly behind the load in time. When that instruction uses the loaded value as an operand, the unit raises a stall request: decode holds, fetch freezes, and a bubble goes into execute. There is one exception. If the dependent instruction is a store that needs the loaded value only as its store data, the unit does not stall. Instead it raises a store-data bypass flag, which travels with the store and selects the load result in the memory stage.

The unit is purely combinational. It has no clock and no reset.

Top module: `opnd_bypass_unit`

## Requirements
- R1: A select output is 2'b01 (execute/memory register) when the instruction in execute is valid, writes a register, and its destination equals the operand's source register.
- R2: A select output is 2'b10 (memory/writeback register) when only the instruction in the memory stage is valid, writes a register, and has a matching destination.
- R3: When both older stages match the same source register, the select is 2'b01: the younger result wins.
- R4: Register 0 never matches. A zero source gives select 2'b00 (register file), and a zero destination never stalls and never raises the store-data bypass.
- R5: A stage whose valid bit or write-enable is clear never matches. With no match, the select is 2'b00.
- R6: The stall request is high when the decode slot is valid and the instruction in execute is a valid, register-writing load whose nonzero destination equals source 1, or equals source 2 of a non-store.
- R7: A valid store whose source 2 (store data) alone matches a load in execute raises the store-data bypass and does not stall. If source 1 also matches that load, the unit stalls and the bypass stays low.
- R8: A load in the memory stage never causes a stall; its match is forwarded with select 2'b10.
- R9: When the decode slot is not valid, both the stall request and the store-data bypass are low. The operand selects are still produced.
- R10: The two operand selects are worked out independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_is_store | input | 1 | Decode instruction is a store (source 2 is store data) |
| id_src1 | input | REG_AW | First source register of the decode instruction |
| id_src2 | input | REG_AW | Second source register of the decode instruction |
| ex_valid | input | 1 | Execute-stage slot holds a real instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_AW | Execute-stage destination register |
| mem_valid | input | 1 | Memory-stage slot holds a real instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| sel_a | output | 2 | Operand A source: 00 register file, 01 exec/mem, 10 mem/wb |
| sel_b | output | 2 | Operand B source, same encoding |
| st_data_byp | output | 1 | Store data must take the load result in the memory stage |
| stall_req | output | 1 | Hold decode and fetch, inject a bubble |

## Verification
The bench sweeps every collision pattern over a small set of register numbers, every combination of the valid, write-enable, load, store and decode-valid flags, and a random stream after that. Each result is compared with a priority model written in the bench.

It targets these faults:
- A swapped priority would send the stale memory-stage value when both stages match.
- A missing register-0 guard would forward or stall on the hardwired zero register.
- Ignoring the valid bit would let flushed slots forward garbage.
- Mishandling the store case would either stall a load/store pair needlessly, or let a store whose address depends on the load proceed with a bypass it cannot use.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } src_sel_e;
endpackage

// File: rtl/opfwd_hit.sv
module opfwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              valid,
  input  logic              wr_en,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  // a bubble, a non-writer or the zero register never supplies a value
  assign hit = valid && wr_en && (dst == src) && (src != ZERO_REG);
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
  import opfwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_valid,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_valid,
  input  logic              mem_wr_en,
  output src_sel_e          sel,
  output logic              ex_hit
);
  logic mem_hit;

  opfwd_hit #(.REG_AW(REG_AW)) u_hit_ex (
    .src(src), .dst(ex_dst), .valid(ex_valid), .wr_en(ex_wr_en), .hit(ex_hit)
  );
  opfwd_hit #(.REG_AW(REG_AW)) u_hit_mem (
    .src(src), .dst(mem_dst), .valid(mem_valid), .wr_en(mem_wr_en), .hit(mem_hit)
  );

  // nearest older writer first
  always_comb begin
    if (ex_hit)       sel = SRC_EXMEM;
    else if (mem_hit) sel = SRC_MEMWB;
    else              sel = SRC_RF;
  end

  always_comb begin
    // R5: a memory-stage pick needs a valid writing instruction there
    p_memwb_needs_writer_r5: assert (sel != SRC_MEMWB || (mem_valid && mem_wr_en && mem_dst == src));
  end
endmodule

// File: rtl/opfwd_hazard.sv
module opfwd_hazard (
  input  logic id_valid,
  input  logic id_is_store,
  input  logic ex_is_load,
  input  logic ld_hit_a,
  input  logic ld_hit_b,
  output logic stall_req,
  output logic st_data_byp
);
  logic use_a, use_b_alu, use_b_st;

  assign use_a     = id_valid && ex_is_load && ld_hit_a;
  assign use_b_alu = id_valid && ex_is_load && ld_hit_b && !id_is_store;
  assign use_b_st  = id_valid && ex_is_load && ld_hit_b && id_is_store;

  assign stall_req   = use_a || use_b_alu;
  assign st_data_byp = use_b_st && !use_a;

  always_comb begin
    // R7: the memory-stage bypass and a stall are never requested together
    p_byp_excl_stall_r7: assert (!(stall_req && st_data_byp));
    // R9: an empty decode slot asks for nothing
    p_idle_quiet_r9: assert (id_valid || (!stall_req && !st_data_byp));
  end
endmodule

// File: rtl/opnd_bypass_unit.sv
module opnd_bypass_unit
  import opfwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              id_valid,
  input  logic              id_is_store,
  input  logic [REG_AW-1:0] id_src1,
  input  logic [REG_AW-1:0] id_src2,
  input  logic              ex_valid,
  input  logic              ex_wr_en,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_valid,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] mem_dst,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              st_data_byp,
  output logic              stall_req
);
  localparam int NUM_SRC = 2;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] srcs [NUM_SRC];
  src_sel_e          sels [NUM_SRC];
  logic [NUM_SRC-1:0] ex_hits;

  assign srcs[0] = id_src1;
  assign srcs[1] = id_src2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    opfwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src      (srcs[g]),
      .ex_dst   (ex_dst),
      .ex_valid (ex_valid),
      .ex_wr_en (ex_wr_en),
      .mem_dst  (mem_dst),
      .mem_valid(mem_valid),
      .mem_wr_en(mem_wr_en),
      .sel      (sels[g]),
      .ex_hit   (ex_hits[g])
    );
  end

  assign sel_a = sels[0];
  assign sel_b = sels[1];

  opfwd_hazard u_hazard (
    .id_valid   (id_valid),
    .id_is_store(id_is_store),
    .ex_is_load (ex_is_load),
    .ld_hit_a   (ex_hits[0]),
    .ld_hit_b   (ex_hits[1]),
    .stall_req  (stall_req),
    .st_data_byp(st_data_byp)
  );

  always_comb begin
    // R4: a zero source always reads the register file
    p_zero_src_rf_r4: assert (id_src1 != ZERO_REG || sel_a == 2'b00);
    // R6: a stall needs a valid writing load in execute
    p_stall_needs_load_r6: assert (!stall_req || (ex_valid && ex_wr_en && ex_is_load && ex_dst != ZERO_REG));
    // R1: an execute-stage pick needs a valid writer there
    p_exmem_needs_writer_r1: assert (sel_b != 2'b01 || (ex_valid && ex_wr_en && ex_dst == id_src2));
  end
endmodule

// File: tb/opnd_bypass_unit_tb.sv
module opnd_bypass_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          id_valid, id_is_store, ex_valid, ex_wr_en, ex_is_load, mem_valid, mem_wr_en;
  logic [AW-1:0] id_src1, id_src2, ex_dst, mem_dst;
  logic [1:0]    sel_a, sel_b;
  logic          st_data_byp, stall_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  opnd_bypass_unit #(.REG_AW(AW)) u_dut (
    .id_valid(id_valid), .id_is_store(id_is_store), .id_src1(id_src1), .id_src2(id_src2),
    .ex_valid(ex_valid), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
    .sel_a(sel_a), .sel_b(sel_b), .st_data_byp(st_data_byp), .stall_req(stall_req)
  );

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (s != 0 && ex_valid && ex_wr_en && ex_dst == s)         return 2'b01;
    else if (s != 0 && mem_valid && mem_wr_en && mem_dst == s) return 2'b10;
    else                                                       return 2'b00;
  endfunction

  function automatic logic ld_hit(logic [AW-1:0] s);
    return id_valid && ex_valid && ex_wr_en && ex_is_load && ex_dst != 0 && ex_dst == s;
  endfunction

  function automatic logic ref_stall();
    return ld_hit(id_src1) || (ld_hit(id_src2) && !id_is_store);
  endfunction

  function automatic logic ref_byp();
    return id_is_store && ld_hit(id_src2) && !ld_hit(id_src1);
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (s1=%0d s2=%0d ex=%0d mem=%0d)",
               tag, act, exp, id_src1, id_src2, ex_dst, mem_dst);
    end
  endtask

  task automatic drive(logic iv, logic ist, logic [AW-1:0] s1, logic [AW-1:0] s2,
                       logic ev, logic ew, logic el, logic [AW-1:0] ed,
                       logic mv, logic mw, logic [AW-1:0] md);
    @(negedge clk);
    id_valid = iv; id_is_store = ist; id_src1 = s1; id_src2 = s2;
    ex_valid = ev; ex_wr_en = ew; ex_is_load = el; ex_dst = ed;
    mem_valid = mv; mem_wr_en = mw; mem_dst = md;
    #2;
  endtask

  task automatic check_all();
    chk("R1 sel_a", sel_a, ref_sel(id_src1));
    chk("R10 sel_b", sel_b, ref_sel(id_src2));
    chk("R6 stall", {1'b0, stall_req}, {1'b0, ref_stall()});
    chk("R7 byp", {1'b0, st_data_byp}, {1'b0, ref_byp()});
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(1234);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #2;
    // idle state after reset: everything from the register file
    chk("R5 idle sel_a", sel_a, 2'b00);
    chk("R5 idle sel_b", sel_b, 2'b00);
    chk("R9 idle stall", {1'b0, stall_req}, 2'b00);

    // directed corners
    drive(1, 0, 3, 4, 1, 1, 0, 3, 0, 0, 0);  chk("R1 ex fwd", sel_a, 2'b01);
    drive(1, 0, 3, 4, 0, 0, 0, 0, 1, 1, 4);  chk("R2 mem fwd", sel_b, 2'b10);
    drive(1, 0, 7, 7, 1, 1, 0, 7, 1, 1, 7);  chk("R3 younger wins", sel_a, 2'b01);
    drive(1, 0, 0, 0, 1, 1, 1, 0, 1, 1, 0);  chk("R4 zero sel", sel_a, 2'b00);
    chk("R4 zero stall", {1'b0, stall_req}, 2'b00);
    drive(1, 0, 5, 5, 0, 1, 0, 5, 1, 0, 5);  chk("R5 invalid/no-we", sel_b, 2'b00);
    drive(1, 0, 6, 1, 1, 1, 1, 6, 0, 0, 0);  chk("R6 load-use stall", {1'b0, stall_req}, 2'b01);
    drive(1, 1, 2, 9, 1, 1, 1, 9, 0, 0, 0);  chk("R7 store byp", {1'b0, st_data_byp}, 2'b01);
    chk("R7 store no stall", {1'b0, stall_req}, 2'b00);
    drive(1, 1, 9, 9, 1, 1, 1, 9, 0, 0, 0);  chk("R7 addr dep stall", {1'b0, stall_req}, 2'b01);
    chk("R7 addr dep no byp", {1'b0, st_data_byp}, 2'b00);
    drive(1, 0, 8, 2, 0, 0, 0, 0, 1, 1, 8);  chk("R8 mem load no stall", {1'b0, stall_req}, 2'b00);
    chk("R8 mem load fwd", sel_a, 2'b10);
    drive(0, 0, 6, 6, 1, 1, 1, 6, 0, 0, 0);  chk("R9 bubble no stall", {1'b0, stall_req}, 2'b00);
    chk("R9 bubble sel", sel_a, 2'b01);
    drive(1, 0, 3, 4, 1, 1, 0, 4, 1, 1, 3);  chk("R10 a mem", sel_a, 2'b10);
    chk("R10 b ex", sel_b, 2'b01);

    // exhaustive collision sweep over registers 0..2 and all flags
    for (int f = 0; f < 128; f++) begin
      for (int r = 0; r < 81; r++) begin
        drive(f[0], f[1], AW'(r % 3), AW'((r / 3) % 3),
              f[2], f[3], f[4], AW'((r / 9) % 3),
              f[5], f[6], AW'((r / 27) % 3));
        check_all();
      end
    end

    // random stream over a narrow register range
    for (int i = 0; i < 3000; i++) begin
      drive(1'($urandom), 1'($urandom), AW'($urandom % 4), AW'($urandom % 4),
            1'($urandom), 1'($urandom), 1'($urandom), AW'($urandom % 4),
            1'($urandom), 1'($urandom), AW'($urandom % 4));
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule